// File: doc/BRIEF.md
# SPI Slave Byte Peripheral

This block lets a processor on a byte-wide, single-beat register bus trade bytes with an external SPI master. The master drives a serial clock, a data line and an active-low select. Each byte it clocks in is captured into a receive register. The byte the processor last placed in the transmit register is clocked back out on the return line during the master's next transaction. Two status flags tell software when a received byte is waiting and when the transmit register can take a new byte.

The SPI pins are sampled by the system clock through a synchroniser. The block works in SPI mode 0 with the most significant bit first. The master must hold each clock phase for several system clock periods. A control register chooses slave operation, which is the state after reset. Setting its top bit parks the serial engine.

Top module: `spi_slave_regs`

## Requirements
- R1: Registers sit at these bus offsets: 0x6 control, 0x9 transmit data, 0xA status, 0xB receive data. Every access is acknowledged with a one-cycle `ack_o` pulse in the cycle after the strobe is sampled, and read data is valid while `ack_o` is high. Reads of any other offset return 0x00. The control register reads back the value last written to it.
- R2: The control register resets to 0x00, which selects slave mode. While control bit 7 is 1, the serial engine ignores the SPI pins, holds `miso_o` low, and neither captures data nor changes any flag.
- R3: Status layout: bit 2 is idle, bit 3 is receive-ready, bit 4 is transmit-ready, and every other bit reads 0. After reset the status reads 0x14.
- R4: Received bits are sampled on rising SCK edges while select is low, MSB first. After the eighth bit the byte is stored in the receive register and receive-ready becomes 1.
- R5: A read of the receive data register clears receive-ready. If a byte completes in the same cycle, receive-ready stays 1.
- R6: A write to the transmit data register clears transmit-ready. The written byte goes out on `miso_o`, MSB first, changing after falling SCK edges, in the next byte the master clocks. The first bit is presented once select goes low. If a byte completes in the same cycle as the write, transmit-ready stays 0.
- R7: When a byte completes, both receive-ready and transmit-ready become 1.
- R8: After a completed byte has set transmit-ready, later bytes send 0x00 until the transmit register is written again. This holds for further bytes within the same select period too.
- R9: Raising select resets the bit counter. A partial byte is discarded: it changes neither flag nor the receive register, and the next full byte is received correctly.
- R10: The idle status bit reads 0 while a byte is partly clocked, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | ADDR_W | Register offset |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data |
| ack_o | output | 1 | Access acknowledge |
| sck_i | input | 1 | SPI clock from master |
| mosi_i | input | 1 | Serial data from master |
| csn_i | input | 1 | Active-low select from master |
| miso_o | output | 1 | Serial data to master |

## Verification
The bench runs 256 full-byte exchanges with distinct transmit and receive patterns. It checks the flags after each write, each transfer and each read. A design that reversed the bit order, dropped the first transmit bit or cleared a flag on the wrong access fails here. Two-byte select periods catch a design that repeats a stale transmit byte instead of sending zeros. An aborted four-bit byte catches a counter that does not reset on select, since that design would merge the fragment into the next byte. The status is also read in the middle of that byte to catch an idle bit that ignores a transfer in progress. A parked engine is driven with live SPI traffic to show that nothing moves.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int unsigned BYTE_W = 8;

  // register offsets in the block
  localparam int unsigned OFF_CTRL = 6;
  localparam int unsigned OFF_TXD  = 9;
  localparam int unsigned OFF_STAT = 10;
  localparam int unsigned OFF_RXD  = 11;

  // status and control bit positions
  localparam int unsigned ST_IDLE_BIT   = 2;
  localparam int unsigned ST_RRDY_BIT   = 3;
  localparam int unsigned ST_TRDY_BIT   = 4;
  localparam int unsigned CTRL_PARK_BIT = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t pack_status(input logic rrdy, input logic trdy, input logic idle);
    byte_t s;
    s = '0;
    s[ST_IDLE_BIT] = idle;
    s[ST_RRDY_BIT] = rrdy;
    s[ST_TRDY_BIT] = trdy;
    return s;
  endfunction

  // byte to load into the shifter at a frame start or a byte boundary
  function automatic byte_t next_tx(input logic wr_now, input byte_t wr_dat,
                                    input logic done_now, input logic trdy,
                                    input byte_t txd);
    if (wr_now)   return wr_dat;
    if (done_now) return '0;
    return trdy ? '0 : txd;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q[g] <= RESET_VAL;
        else         stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q[g] <= RESET_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              csn_i,
  input  logic [DATA_W-1:0] load_byte_i,
  output logic              frame_start_o,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              busy_o,
  output logic              miso_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_q, csn_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rx_sh_q, tx_sh_q;
  logic              active, sck_rise, sck_fall;

  assign active        = en_i & ~csn_i;
  assign sck_rise      = active & sck_i & ~sck_q;
  assign sck_fall      = active & ~sck_i & sck_q;
  assign frame_start_o = active & csn_q;
  assign byte_done_o   = sck_rise && (bit_cnt_q == LAST);
  assign rx_byte_o     = {rx_sh_q[DATA_W-2:0], mosi_i};
  assign busy_o        = active && (bit_cnt_q != '0);
  assign miso_o        = active & tx_sh_q[DATA_W-1];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      csn_q     <= 1'b1;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
    end else begin
      sck_q <= sck_i;
      csn_q <= csn_i;
      if (!active) begin
        bit_cnt_q <= '0;
      end else if (sck_rise) begin
        rx_sh_q   <= {rx_sh_q[DATA_W-2:0], mosi_i};
        bit_cnt_q <= (bit_cnt_q == LAST) ? '0 : bit_cnt_q + 1'b1;
      end
      if (frame_start_o || byte_done_o) begin
        tx_sh_q <= load_byte_i;
      end else if (sck_fall && (bit_cnt_q != '0)) begin
        tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_slave_regs.sv
module spi_slave_regs
  import spi_slave_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [7:0]        dat_i,
  output logic [7:0]        dat_o,
  output logic              ack_o,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              csn_i,
  output logic              miso_o
);
  logic [2:0] pins_s;
  logic       sck_s, mosi_s, csn_s;

  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .async_i({csn_i, mosi_i, sck_i}), .sync_o(pins_s)
  );
  assign {csn_s, mosi_s, sck_s} = pins_s;

  byte_t ctrl_q, txd_q, rxd_q, rdat_q;
  logic  ack_q, rrdy_q, trdy_q;
  logic  acc, tx_write, ctrl_write, rx_read, slave_en;
  logic  frame_start, byte_done, busy;
  byte_t rx_byte, load_byte, rd_mux;

  assign acc        = cyc_i & stb_i & ~ack_q;
  assign tx_write   = acc & we_i & (adr_i == ADDR_W'(OFF_TXD));
  assign ctrl_write = acc & we_i & (adr_i == ADDR_W'(OFF_CTRL));
  assign rx_read    = acc & ~we_i & (adr_i == ADDR_W'(OFF_RXD));
  assign slave_en   = ~ctrl_q[CTRL_PARK_BIT];
  assign load_byte  = next_tx(tx_write, dat_i, byte_done, trdy_q, txd_q);

  spi_shift_engine #(.DATA_W(BYTE_W)) i_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(slave_en),
    .sck_i(sck_s), .mosi_i(mosi_s), .csn_i(csn_s),
    .load_byte_i(load_byte), .frame_start_o(frame_start),
    .byte_done_o(byte_done), .rx_byte_o(rx_byte),
    .busy_o(busy), .miso_o(miso_o)
  );

  always_comb begin
    rd_mux = '0;
    if (adr_i == ADDR_W'(OFF_CTRL))      rd_mux = ctrl_q;
    else if (adr_i == ADDR_W'(OFF_STAT)) rd_mux = pack_status(rrdy_q, trdy_q, ~busy);
    else if (adr_i == ADDR_W'(OFF_RXD))  rd_mux = rxd_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
      ctrl_q <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      rrdy_q <= 1'b0;
      trdy_q <= 1'b1;
    end else begin
      ack_q  <= acc;
      rdat_q <= (acc & ~we_i) ? rd_mux : '0;
      if (ctrl_write) ctrl_q <= dat_i;
      if (tx_write)   txd_q  <= dat_i;
      if (byte_done)  rxd_q  <= rx_byte;
      if (byte_done)    rrdy_q <= 1'b1;
      else if (rx_read) rrdy_q <= 1'b0;
      if (tx_write)       trdy_q <= 1'b0;
      else if (byte_done) trdy_q <= 1'b1;
    end
  end

  assign ack_o = ack_q;
  assign dat_o = rdat_q;

  logic unused_frame;
  assign unused_frame = frame_start;
endmodule

// File: rtl/spi_slave_regs_chk.sv
module spi_slave_regs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_i,
  input logic byte_done_i,
  input logic rx_read_i,
  input logic tx_write_i,
  input logic rrdy_i,
  input logic trdy_i,
  input logic busy_i,
  input logic slave_en_i,
  input logic miso_i
);
  // R1
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ack_i);
  // R2
  parked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_en_i |-> (!miso_i && !byte_done_i));
  // R4
  rrdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> rrdy_i);
  // R5
  rrdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_read_i && !byte_done_i) |=> !rrdy_i);
  // R6
  trdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_write_i |=> !trdy_i);
  // R7
  trdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && !tx_write_i) |=> trdy_i);
  // R10
  idle_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> !busy_i);
endmodule

bind spi_slave_regs spi_slave_regs_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_o),
  .byte_done_i(byte_done), .rx_read_i(rx_read), .tx_write_i(tx_write),
  .rrdy_i(rrdy_q), .trdy_i(trdy_q), .busy_i(busy),
  .slave_en_i(slave_en), .miso_i(miso_o)
);

// File: tb/test_spi_slave_regs.sv
module test_spi_slave_regs;
  localparam int HP = 10;
  localparam logic [3:0] A_CTRL = 4'h6, A_TXD = 4'h9, A_STAT = 4'hA, A_RXD = 4'hB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 0, stb = 0, we = 0;
  logic [3:0] adr = '0;
  logic [7:0] wdat = '0, rdat;
  logic ack, sck = 0, mosi = 0, csn = 1, miso;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_slave_regs i_spi_slave_regs (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack),
    .sck_i(sck), .mosi_i(mosi), .csn_i(csn), .miso_o(miso)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk); d = rdat; cyc = 0; stb = 0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(negedge clk); cyc = 0; stb = 0; we = 0;
  endtask

  task automatic cs_lo(); @(negedge clk); csn = 0; repeat (HP) @(negedge clk); endtask
  task automatic cs_hi(); repeat (HP) @(negedge clk); csn = 1; repeat (2*HP) @(negedge clk); endtask

  task automatic spi_bits(input logic [7:0] mo, input int n, output logic [7:0] mi);
    mi = '0;
    for (int b = 7; b > 7 - n; b--) begin
      mosi = mo[b];
      repeat (HP) @(negedge clk);
      mi[b] = miso;
      sck = 1;
      repeat (HP) @(negedge clk);
      sck = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got, txv, mov;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R3 reset state
    bus_rd(A_STAT, d); chk("R3 reset status", d, 8'h14);
    bus_rd(A_RXD, d);  chk("R1 reset rx", d, 8'h00);
    bus_rd(A_CTRL, d); chk("R2 reset ctrl", d, 8'h00);
    chk("R2 reset miso", {7'b0, miso}, 8'h00);
    bus_rd(4'h0, d);   chk("R1 unmapped read", d, 8'h00);
    // R1 ack timing
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = A_STAT;
    chk("R1 ack low at strobe", {7'b0, ack}, 8'h00);
    @(negedge clk); chk("R1 ack one cycle later", {7'b0, ack}, 8'h01);
    cyc = 0; stb = 0;
    @(negedge clk); chk("R1 ack single pulse", {7'b0, ack}, 8'h00);

    // sweep: R4 R5 R6 R7
    for (int i = 0; i < 256; i++) begin
      txv = 8'(i) ^ 8'h5A;
      mov = 8'(i * 37 + 11);
      bus_wr(A_TXD, txv);
      bus_rd(A_STAT, d); chk("R6 trdy cleared by write", d, 8'h04);
      cs_lo(); spi_bits(mov, 8, got); cs_hi();
      chk("R6 tx byte shifted out", got, txv);
      bus_rd(A_STAT, d); chk("R7 flags set on completion", d, 8'h1C);
      bus_rd(A_RXD, d);  chk("R4 received byte", d, mov);
      bus_rd(A_STAT, d); chk("R5 rrdy cleared by read", d, 8'h14);
    end

    // R8 no write: zeros
    cs_lo(); spi_bits(8'hC3, 8, got); cs_hi();
    chk("R8 idle tx sends zero", got, 8'h00);
    bus_rd(A_RXD, d); chk("R4 rx after zero send", d, 8'hC3);

    // R8 two bytes in one select
    bus_wr(A_TXD, 8'hA5);
    cs_lo();
    spi_bits(8'h12, 8, got); chk("R6 first byte of pair", got, 8'hA5);
    spi_bits(8'h34, 8, got); chk("R8 second byte zero", got, 8'h00);
    cs_hi();
    bus_rd(A_STAT, d); chk("R7 status after pair", d, 8'h1C);
    bus_rd(A_RXD, d);  chk("R4 last byte of pair", d, 8'h34);

    // R9 R10 partial byte
    cs_lo(); spi_bits(8'hF0, 4, got);
    bus_rd(A_STAT, d); chk("R10 busy mid byte", d, 8'h10);
    cs_hi();
    bus_rd(A_STAT, d); chk("R9 partial no flag", d, 8'h14);
    bus_rd(A_RXD, d);  chk("R9 rx unchanged", d, 8'h34);
    cs_lo(); spi_bits(8'h81, 8, got); cs_hi();
    bus_rd(A_RXD, d);  chk("R9 full byte after abort", d, 8'h81);

    // R2 parked engine
    bus_wr(A_CTRL, 8'h80);
    bus_rd(A_CTRL, d); chk("R1 ctrl readback", d, 8'h80);
    cs_lo(); spi_bits(8'h3C, 8, got); cs_hi();
    chk("R2 parked miso low", got, 8'h00);
    bus_rd(A_STAT, d); chk("R2 parked no flags", d, 8'h14);
    bus_rd(A_RXD, d);  chk("R2 parked rx kept", d, 8'h81);
    bus_wr(A_CTRL, 8'h00);
    cs_lo(); spi_bits(8'h3C, 8, got); cs_hi();
    bus_rd(A_RXD, d);  chk("R2 slave mode restored", d, 8'h3C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule